// File: doc/BRIEF.md
# Push-Button Power-Up Sequencer

This block switches on a set of seven regulator rails in a staged order whenever a wake event arrives. A wake event is a press of an active-low push-button, or a charger that has just become valid. The first rail comes up at once. Each later group of rails waits until a rail that is already on has shown power-good without a break for a set number of milliseconds. A free-running prescaler divides the clock into a one-millisecond tick, and that tick sets all of the timing.

While the rails come up, the system processor must claim power by raising its hold input. If a button press started the wake and the button is released before hold is high, every rail is switched off. If the charger started the wake, hold must rise within a fixed window or everything is switched off. Once hold is high, the rails stay on until hold drops while the button is released. While the system is on, a processor power-enable input can drop the rails it owns. An active-low button-status output reports the synchronised button level to the processor.

Top module: `pb_pwrup_seq`

## Requirements
- R1: From reset, a low level on `pb_n_i` enables regulator 5 within 4 clock cycles. A rising edge of `chg_ok_i` also starts a sequence, and regulator 5 is enabled within 4 cycles.
- R2: Bit k of `rail_en_o` enables regulator k+1. At the start of a sequence regulator 5 (bit 4) is the only rail enabled.
- R3: Regulators 2, 3 and 4 (bits 1 to 3) switch on together once regulator 5 has been power-good without a break for R5_DLY_MS ticks. Measured from the enable of regulator 5, this takes between 7 and 8 ms plus 4 cycles at the default setting.
- R4: Regulators 1 and 6 (bits 0 and 5) switch on together once regulator 2 has been power-good without a break for R2_DLY_MS ticks. This takes 7 to 8 ms plus 4 cycles after regulator 2 is enabled.
- R5: Regulator 7 (bit 6) switches on once regulator 2 has been power-good without a break for R2_LATE_MS ticks. This takes 15 to 16 ms plus 4 cycles after regulator 2 is enabled.
- R6: In a sequence started by the button, releasing the button while `hold_i` is low clears every enable within 4 cycles.
- R7: In a sequence started by the charger, if `hold_i` is not high within CHG_WIN_MS ticks, every enable is cleared. A charger input that stays high does not start a new sequence.
- R8: Once `hold_i` is high, the rails stay on after the button is released. If `hold_i` then drops with the button released, every enable is low one cycle after the clock edge that samples it.
- R9: If a watched rail loses power-good before its delay has run out, its timer restarts from zero, and the rails that depend on it wait the full delay again.
- R10: `pb_stat_n_o` is low while the synchronised button is pressed and high otherwise. The button passes through a two-flop synchroniser first.
- R11: While the system is on, `pwren_i` low clears the enables of regulators 2, 3, 4, 6 and 7 (mask 7'b1101110) and leaves regulators 1 and 5 on. Raising `pwren_i` again restores them at once.
- R12: After reset every enable is low and `pb_stat_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_n_i | input | 1 | Push-button, active low, asynchronous |
| chg_ok_i | input | 1 | Charger present and valid |
| hold_i | input | 1 | Processor claims power |
| pwren_i | input | 1 | Processor power-enable for its owned rails |
| pgood_i | input | 7 | Power-good per regulator, bit k is regulator k+1 |
| rail_en_o | output | 7 | Regulator enables, bit k is regulator k+1 |
| pb_stat_n_o | output | 1 | Synchronised button status, active low |

## Verification
The assertions assume that each power-good input is a clean, synchronous level. They also assume that power-good for a rail rises only after that rail is enabled, and that hold is a plain level that needs no synchroniser. The bench meets these assumptions with a regulator model that returns each enable as power-good half a cycle later. A mask in the bench can force a rail's power-good low to exercise timer restarts. The bench changes hold and button levels only on falling clock edges. It chooses random release times only from ranges that lie clear of the tolerance windows, so each expected enable pattern is unambiguous.

// File: rtl/pb_seq_pkg.sv
package pb_seq_pkg;

   localparam int unsigned RAIL_COUNT = 7;

   typedef enum logic [1:0] {
      PS_OFF = 2'd0,
      PS_SEQ = 2'd1,
      PS_ON  = 2'd2
   } pwr_state_e;

   // bit k drives regulator k+1
   localparam logic [RAIL_COUNT-1:0] MSK_FIRST = 7'b0010000;
   localparam logic [RAIL_COUNT-1:0] MSK_GRP_A = 7'b0001110;
   localparam logic [RAIL_COUNT-1:0] MSK_GRP_B = 7'b0100001;
   localparam logic [RAIL_COUNT-1:0] MSK_GRP_C = 7'b1000000;
   localparam logic [RAIL_COUNT-1:0] MSK_OWNED = 7'b1101110;

   localparam int unsigned IDX_REG2 = 1;
   localparam int unsigned IDX_REG5 = 4;

endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pb_tick_gen.sv
module pb_tick_gen #(
   parameter int unsigned DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);

   if (DIV < 1) begin : g_bad_div
      $error("pb_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every_cycle
      logic tick_unused;
      assign tick_unused = clk ^ rst_n;
      assign tick_o = 1'b1;
   end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             div_q <= '0;
         else if (div_q == LAST) div_q <= '0;
         else                    div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);  // R3
   end

endmodule

// File: rtl/pg_timer.sv
module pg_timer #(
   parameter int unsigned LIM_A = 8,
   parameter int unsigned LIM_B = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic pg_i,
   input  logic tick_i,
   output logic hit_a_o,
   output logic hit_b_o
);

   if (LIM_A < 1) begin : g_bad_a
      $error("pg_timer: LIM_A must be at least 1");
   end
   if (LIM_B < LIM_A) begin : g_bad_b
      $error("pg_timer: LIM_B must not be below LIM_A");
   end

   localparam int unsigned CW = $clog2(LIM_B + 1);
   localparam logic [CW-1:0] CAP_A = CW'(LIM_A);
   localparam logic [CW-1:0] CAP_B = CW'(LIM_B);

   logic [CW-1:0] ms_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ms_q <= '0;
      else if (!(run_i && pg_i))        ms_q <= '0;
      else if (tick_i && ms_q < CAP_B)  ms_q <= ms_q + 1'b1;
   end

   assign hit_a_o = (ms_q >= CAP_A);
   assign hit_b_o = (ms_q >= CAP_B);

   AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_i |=> (ms_q == '0));  // R9
   AST_TMR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_q != $past(ms_q)) |-> (ms_q == '0 || ms_q == CW'($past(ms_q) + 1'b1)));  // R9

endmodule

// File: rtl/pb_pwrup_seq.sv
module pb_pwrup_seq
   import pb_seq_pkg::*;
#(
   parameter int unsigned TICK_DIV    = 1000,
   parameter int unsigned R5_DLY_MS   = 8,
   parameter int unsigned R2_DLY_MS   = 8,
   parameter int unsigned R2_LATE_MS  = 16,
   parameter int unsigned CHG_WIN_MS  = 260,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pb_n_i,
   input  logic                  chg_ok_i,
   input  logic                  hold_i,
   input  logic                  pwren_i,
   input  logic [RAIL_COUNT-1:0] pgood_i,
   output logic [RAIL_COUNT-1:0] rail_en_o,
   output logic                  pb_stat_n_o
);

   if (R2_LATE_MS < R2_DLY_MS) begin : g_bad_late
      $error("pb_pwrup_seq: R2_LATE_MS must not be below R2_DLY_MS");
   end
   if (CHG_WIN_MS < 1) begin : g_bad_win
      $error("pb_pwrup_seq: CHG_WIN_MS must be at least 1");
   end

   localparam int unsigned WIN_W = $clog2(CHG_WIN_MS + 1);
   localparam logic [WIN_W-1:0] WIN_END = WIN_W'(CHG_WIN_MS);

   logic             tick, pb_s, pressed, active;
   pwr_state_e       state_q, state_nx;
   logic             src_chg_q, chg_q;
   logic [WIN_W-1:0] win_q;
   logic             win_done;
   logic             stg_a_q, stg_b_q, stg_c_q;
   logic             t5_hit, t5_unused_b, t2_hit_mid, t2_hit_late;

   pb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pb_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pb_n_i), .q_o(pb_s));

   pb_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   assign pressed = ~pb_s;
   assign active  = (state_q != PS_OFF);

   pg_timer #(.LIM_A(R5_DLY_MS), .LIM_B(R5_DLY_MS)) u_tmr_r5 (
      .clk(clk), .rst_n(rst_n), .run_i(active), .pg_i(pgood_i[IDX_REG5]),
      .tick_i(tick), .hit_a_o(t5_hit), .hit_b_o(t5_unused_b));

   pg_timer #(.LIM_A(R2_DLY_MS), .LIM_B(R2_LATE_MS)) u_tmr_r2 (
      .clk(clk), .rst_n(rst_n), .run_i(active), .pg_i(pgood_i[IDX_REG2]),
      .tick_i(tick), .hit_a_o(t2_hit_mid), .hit_b_o(t2_hit_late));

   assign win_done = (win_q >= WIN_END);

   always_comb begin
      state_nx = state_q;
      unique case (state_q)
         PS_OFF: if (pressed || (chg_ok_i && !chg_q)) state_nx = PS_SEQ;
         PS_SEQ: begin
            if (hold_i)                              state_nx = PS_ON;
            else if (!src_chg_q && !pressed)         state_nx = PS_OFF;
            else if (src_chg_q && win_done)          state_nx = PS_OFF;
         end
         PS_ON:  if (!hold_i && !pressed)            state_nx = PS_OFF;
         default:                                    state_nx = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PS_OFF;
         src_chg_q <= 1'b0;
         chg_q     <= 1'b0;
      end else begin
         state_q <= state_nx;
         chg_q   <= chg_ok_i;
         if (state_q == PS_OFF && state_nx == PS_SEQ) src_chg_q <= !pressed;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            win_q <= '0;
      else if (state_q != PS_SEQ)            win_q <= '0;
      else if (tick && !win_done)            win_q <= win_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_a_q <= 1'b0;
         stg_b_q <= 1'b0;
         stg_c_q <= 1'b0;
      end else if (!active) begin
         stg_a_q <= 1'b0;
         stg_b_q <= 1'b0;
         stg_c_q <= 1'b0;
      end else begin
         if (t5_hit)      stg_a_q <= 1'b1;
         if (t2_hit_mid)  stg_b_q <= 1'b1;
         if (t2_hit_late) stg_c_q <= 1'b1;
      end
   end

   always_comb begin
      rail_en_o = '0;
      if (active) begin
         rail_en_o = MSK_FIRST
                   | ({RAIL_COUNT{stg_a_q}} & MSK_GRP_A)
                   | ({RAIL_COUNT{stg_b_q}} & MSK_GRP_B)
                   | ({RAIL_COUNT{stg_c_q}} & MSK_GRP_C);
         if (state_q == PS_ON && !pwren_i) rail_en_o = rail_en_o & ~MSK_OWNED;
      end
   end

   assign pb_stat_n_o = pb_s;

   AST_GRP_A_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stg_a_q) |-> $past(pgood_i[IDX_REG5]));  // R3
   AST_GRP_B_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stg_b_q) |-> $past(pgood_i[IDX_REG2]));  // R4
   AST_LATE_AFTER_MID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stg_c_q) |-> stg_b_q);  // R5
   AST_RELEASE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SEQ && !src_chg_q && !hold_i && pb_s) |=> (rail_en_o == '0));  // R6
   AST_CHG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_SEQ && src_chg_q && !hold_i && win_done) |=> (state_q == PS_OFF));  // R7
   AST_HOLD_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_ON && !hold_i && pb_s) |=> (rail_en_o == '0));  // R8
   AST_START_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_OFF && state_nx == PS_SEQ) |=> (rail_en_o == MSK_FIRST));  // R2

endmodule

// File: tb/pb_pwrup_seq_tb_top.sv
module pb_pwrup_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int D = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pb_n = 1'b1, chg_ok = 1'b0, hold = 1'b0, pwren = 1'b1;
   logic [6:0] pgood = '0, pg_mask = '0;
   logic [6:0] rail_en;
   logic       pb_stat_n;

   int nchk = 0, nfail = 0, cyc = 0;
   int rise_cyc [7];
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pb_pwrup_seq #(.TICK_DIV(D), .R5_DLY_MS(8), .R2_DLY_MS(8), .R2_LATE_MS(16),
                  .CHG_WIN_MS(260), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pb_n_i(pb_n), .chg_ok_i(chg_ok), .hold_i(hold),
      .pwren_i(pwren), .pgood_i(pgood), .rail_en_o(rail_en), .pb_stat_n_o(pb_stat_n));

   // regulator model: power-good follows enable unless masked
   always @(negedge clk) begin
      cyc <= cyc + 1;
      pgood <= rail_en & ~pg_mask;
      for (int i = 0; i < 7; i++)
         if (rail_en[i] && rise_cyc[i] < 0) rise_cyc[i] = cyc;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_win(input string req, input int d, input int lo, input int hi);
      nchk++;
      if (d < lo || d > hi) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, d, lo, hi);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_rise();
      for (int i = 0; i < 7; i++) rise_cyc[i] = -1;
   endtask

   task automatic quiet();
      hold = 1'b0; pb_n = 1'b1; chg_ok = 1'b0; pwren = 1'b1; pg_mask = '0;
      wait_cyc(8);
   endtask

   // expected enables after a random press/release, by release-time group
   function automatic logic [6:0] exp_mask(input int grp, input bit held);
      logic [6:0] m;
      if (!held) return 7'h00;
      m = 7'b0010000;
      if (grp >= 1) m |= 7'b0001110;
      if (grp >= 2) m |= 7'b0100001;
      if (grp >= 3) m |= 7'b1000000;
      return m;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int t0;
      int bases [4];
      bases = '{3, 10, 19, 30};
      void'($urandom(32'd20240611));
      clr_rise();
      wait_cyc(5);
      chk(rail_en == 7'h00, "R12 enables after reset", rail_en, 0);
      chk(pb_stat_n == 1'b1, "R12 status after reset", pb_stat_n, 1);
      rst_n = 1'b1;
      wait_cyc(4);

      // button start, full ramp, hold, release
      clr_rise();
      pb_n = 1'b0;
      wait_cyc(4);
      chk(rail_en == 7'b0010000, "R1 R2 first rail only", rail_en, 7'b0010000);
      chk(pb_stat_n == 1'b0, "R10 status pressed", pb_stat_n, 0);
      wait_cyc(30 * D);
      chk_win("R3 grp A delay", rise_cyc[1] - rise_cyc[4], 7*D, 8*D + 4);
      chk(rise_cyc[2] == rise_cyc[1] && rise_cyc[3] == rise_cyc[1], "R3 grp A together",
          rise_cyc[3], rise_cyc[1]);
      chk_win("R4 grp B delay", rise_cyc[0] - rise_cyc[1], 7*D, 8*D + 4);
      chk(rise_cyc[5] == rise_cyc[0], "R4 grp B together", rise_cyc[5], rise_cyc[0]);
      chk_win("R5 late rail delay", rise_cyc[6] - rise_cyc[1], 15*D, 16*D + 4);
      hold = 1'b1;
      wait_cyc(4);
      pb_n = 1'b1;
      wait_cyc(10 * D);
      chk(rail_en == 7'h7f, "R8 stays on after release", rail_en, 7'h7f);
      chk(pb_stat_n == 1'b1, "R10 status released", pb_stat_n, 1);
      pwren = 1'b0;
      wait_cyc(2);
      chk(rail_en == 7'b0010001, "R11 owned rails dropped", rail_en, 7'b0010001);
      pwren = 1'b1;
      wait_cyc(2);
      chk(rail_en == 7'h7f, "R11 owned rails restored", rail_en, 7'h7f);
      hold = 1'b0;
      wait_cyc(1);
      chk(rail_en == 7'h00, "R8 hold drop clears", rail_en, 0);
      quiet();

      // release without hold
      pb_n = 1'b0;
      wait_cyc(12 * D);
      chk(rail_en == 7'b0011110, "R3 R4 mid ramp pattern", rail_en, 7'b0011110);
      pb_n = 1'b1;
      wait_cyc(4);
      chk(rail_en == 7'h00, "R6 release without hold", rail_en, 0);
      quiet();

      // power-good glitch restarts timer
      pb_n = 1'b0;
      wait_cyc(4 + 5 * D);
      pg_mask[4] = 1'b1;
      wait_cyc(2);
      pg_mask[4] = 1'b0;
      wait_cyc(6 * D);
      chk(rail_en[1] == 1'b0, "R9 timer restarted", rail_en[1], 0);
      wait_cyc(4 * D);
      chk(rail_en[1] == 1'b1, "R9 delay then on", rail_en[1], 1);
      quiet();

      // charger start, no hold
      chg_ok = 1'b1;
      wait_cyc(4);
      chk(rail_en == 7'b0010000, "R1 charger start", rail_en, 7'b0010000);
      wait_cyc(250 * D);
      chk(rail_en == 7'h7f, "R7 on inside window", rail_en, 7'h7f);
      wait_cyc(12 * D);
      chk(rail_en == 7'h00, "R7 window expired", rail_en, 0);
      wait_cyc(20 * D);
      chk(rail_en == 7'h00, "R7 held charger no restart", rail_en, 0);
      quiet();

      // charger start, hold in time
      chg_ok = 1'b1;
      wait_cyc(100 * D);
      hold = 1'b1;
      wait_cyc(300 * D);
      chk(rail_en == 7'h7f, "R7 R8 hold within window", rail_en, 7'h7f);
      hold = 1'b0;
      wait_cyc(1);
      chk(rail_en == 7'h00, "R8 hold drop after charger", rail_en, 0);
      quiet();

      // random press/release with or without hold
      for (int it = 0; it < 16; it++) begin
         int grp, rel, hpos;
         bit use_hold;
         logic [6:0] exp;
         grp = int'($urandom % 4);
         rel = bases[grp] + int'($urandom % 3);
         use_hold = 1'($urandom % 2);
         hpos = 1 + int'($urandom % (rel - 1));
         pb_n = 1'b0;
         wait_cyc(hpos * D);
         if (use_hold) hold = 1'b1;
         wait_cyc((rel - hpos) * D);
         pb_n = 1'b1;
         wait_cyc(6);
         exp = exp_mask(grp, use_hold);
         chk(rail_en == exp, use_hold ? "R8 random hold kept" : "R6 random no hold",
             rail_en, exp);
         hold = 1'b0;
         wait_cyc(2);
         chk(rail_en == 7'h00, "R8 random teardown", rail_en, 0);
         quiet();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule